// File: doc/BRIEF.md
# Configuration Header Register File

This block is the target-side configuration space of a single-function device on a parallel expansion bus. Configuration cycles arrive already decoded from the pins as a register access: a 4-bit command code, a dword index, four byte-lane enables and 32 bits of write data. The block keeps the 64-byte standard header and returns read data. The header holds fixed identification fields, the command and status registers, a memory base address register, an I/O base address register, an expansion ROM base register, and the interrupt routing byte. Everything past the header reads as zero.

Software finds the size of each base address register by writing all ones to it and reading it back. Address bits below the implemented window are tied to zero, and each register kind carries its own fixed low-bit code. The error bits in status are set by one-cycle event pulses from the rest of the device. They stay set until a configuration write puts a one on them. The command enables drive plain output pins that gate the device's decoders and its bus-master engine.

The request side has no back-pressure: the block accepts a request in every cycle that `req_valid` is high. Each configuration access gets exactly one `rsp_valid` pulse on the next cycle, and the response has no ready, because the consumer must take it in that cycle. Requests with any other command code get no response.

Top module: `cfg_header_regs`

## Requirements
- R1: Only command 4'b1010 (configuration read) and 4'b1011 (configuration write) are acted on. A request with any other code produces no response and changes no register.
- R2: A configuration request accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. A read returns the header value in `rsp_rdata`, and a write returns zero. A write takes effect at that same edge.
- R3: Write byte enable `req_be[k]` qualifies bits 8k+7:8k of every writable field. A lane whose enable is low keeps its old value.
- R4: Dword 4 is the memory base register. Bit 0 reads 0, bits 2:1 read the placement type parameter (00 any 32-bit, 01 below 1 MB, 10 any 64-bit), and bit 3 reads the prefetchable parameter. All bits below MEM_SIZE_LOG2 other than bits 3:1 read 0, and the bits above are writable.
- R5: Dword 5 is the I/O base register. Bit 0 reads 1, bit 1 reads 0, and bits below IO_SIZE_LOG2 read 0. The bits above are writable.
- R6: Dword 12 is the expansion ROM base register. Bit 0 is the decode enable and drives `rom_decode_en`. Bits 1 up to ROM_SIZE_LOG2-1 read 0, and the bits above are writable.
- R7: Status bits 8, 11, 12, 13, 14 and 15 (dword 1 bits 24, 27..31) are set by the events `evt_master_dpe`, `evt_tabort_sig`, `evt_tabort_rcv`, `evt_master_abort`, `evt_serr_sig` and `evt_parity_det` respectively. They are cleared only by a write with `req_be[3]` high and a 1 in that bit. When an event and a clear meet in one cycle, the event wins.
- R8: Command bits 9:0 (dword 1 bits 9:0) are writable, and bits 15:10 read 0. `io_space_en` is bit 0, `mem_space_en` is bit 1 and `bus_master_en` is bit 2.
- R9: Status bits 10:9 read the select-timing parameter (00 fast, 01 medium, 10 slow), and bit 7 reads the fast back-to-back capability parameter. The other status bits outside R7 read 0.
- R10: Dword 0 ({device ID, vendor ID}), dword 2 ({class code, revision}) and dword 15 bits 15:8 (interrupt pin) are read-only and ignore writes.
- R11: Dword 15 bits 7:0 (interrupt line) are writable. Dwords 3, 6 to 11, 13, 14 and 16 to 63 read zero.
- R12: After reset, command, sticky status, all base registers, the ROM enable and the interrupt line are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Bus command code |
| req_index | input | IDX_W | Dword index into configuration space |
| req_be | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after an accepted configuration access |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| evt_parity_det | input | 1 | Parity error detected event |
| evt_serr_sig | input | 1 | System error signalled event |
| evt_master_abort | input | 1 | Master abort received event |
| evt_tabort_rcv | input | 1 | Target abort received event |
| evt_tabort_sig | input | 1 | Target abort signalled event |
| evt_master_dpe | input | 1 | Data parity error seen as master event |
| io_space_en | output | 1 | I/O decode enable |
| mem_space_en | output | 1 | Memory decode enable |
| bus_master_en | output | 1 | Bus mastering enable |
| rom_decode_en | output | 1 | Expansion ROM decode enable |

## Verification
Each response arrives one cycle after its request. The bench drives a request on a falling edge and samples `rsp_valid` and `rsp_rdata` on the next falling edge, after exactly one register stage. The command enables and `rom_decode_en` also change at the edge that takes a write, so the bench compares them at that same falling edge. An event pulse sets its status bit at the edge where it is sampled, so a read issued on the next cycle already shows it, and the bench's model applies any clear first and then the set in that order.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int IDX_ID      = 0;
  localparam int IDX_CMDSTAT = 1;
  localparam int IDX_CLASS   = 2;
  localparam int IDX_MEMBAR  = 4;
  localparam int IDX_IOBAR   = 5;
  localparam int IDX_ROMBAR  = 12;
  localparam int IDX_INTR    = 15;

  // status bit positions (within the 16-bit status half)
  localparam int ST_MDPE = 8;
  localparam int ST_STA  = 11;
  localparam int ST_RTA  = 12;
  localparam int ST_RMA  = 13;
  localparam int ST_SSE  = 14;
  localparam int ST_DPE  = 15;

  localparam logic [15:0] STICKY_MASK = 16'hF900;
  localparam logic [15:0] CMD_RW_MASK = 16'h03FF;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++) begin
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_hdr_pkg::*;
#(
  parameter int         SIZE_LOG2  = 12,
  parameter logic [3:0] LOW_BITS   = 4'b0000,
  parameter bit         HAS_ENABLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] rdata,
  output logic        enable
);
  localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);

  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (wr_en)  base_q <= lane_merge(base_q, wdata, be) & ADDR_MASK;
  end

  generate
    if (HAS_ENABLE) begin : g_en
      logic en_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              en_q <= 1'b0;
        else if (wr_en && be[0]) en_q <= wdata[0];
      end
      assign enable = en_q;
      assign rdata  = base_q | {28'd0, LOW_BITS[3:1], en_q};
    end else begin : g_fixed
      assign enable = 1'b0;
      assign rdata  = base_q | {28'd0, LOW_BITS};
    end
  endgenerate
endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_hdr_pkg::*;
#(
  parameter logic [1:0] SEL_TIMING = 2'b01,
  parameter bit         FB2B_CAP   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic [15:0] evt_set,
  output logic [15:0] cmd_o,
  output logic [15:0] status_o
);
  logic [15:0] cmd_q, cmd_nx;
  logic [15:0] sticky_q, clr;

  always_comb begin
    cmd_nx = cmd_q;
    if (be[0]) cmd_nx[7:0]  = wdata[7:0];
    if (be[1]) cmd_nx[15:8] = wdata[15:8];
    clr = wr_en ? (wdata[31:16] & {{8{be[3]}}, {8{be[2]}}} & STICKY_MASK) : 16'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      sticky_q <= '0;
    end else begin
      if (wr_en) cmd_q <= cmd_nx & CMD_RW_MASK;
      sticky_q <= ((sticky_q & ~clr) | evt_set) & STICKY_MASK;
    end
  end

  assign cmd_o    = cmd_q;
  assign status_o = sticky_q | {5'd0, SEL_TIMING, 1'b0, FB2B_CAP, 7'd0};
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter int          IDX_W         = 6,
  parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID     = 16'h0B17,
  parameter logic [23:0] CLASS_CODE    = 24'h058000,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int          MEM_SIZE_LOG2 = 12,
  parameter logic [1:0]  MEM_TYPE      = 2'b00,
  parameter bit          MEM_PREFETCH  = 1'b0,
  parameter int          IO_SIZE_LOG2  = 8,
  parameter int          ROM_SIZE_LOG2 = 14,
  parameter logic [1:0]  SEL_TIMING    = 2'b01,
  parameter bit          FB2B_CAP      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_cmd,
  input  logic [IDX_W-1:0] req_index,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic             evt_parity_det,
  input  logic             evt_serr_sig,
  input  logic             evt_master_abort,
  input  logic             evt_tabort_rcv,
  input  logic             evt_tabort_sig,
  input  logic             evt_master_dpe,
  output logic             io_space_en,
  output logic             mem_space_en,
  output logic             bus_master_en,
  output logic             rom_decode_en
);
  localparam logic [3:0] MEM_LOW = {MEM_PREFETCH, MEM_TYPE, 1'b0};

  logic        is_rd, is_wr;
  int          idx_i;
  logic        wr_cs, wr_mem, wr_io, wr_rom, wr_intr;
  logic [15:0] evt_set, cmd_w, status_w;
  logic [31:0] mem_rd, io_rd, rom_rd, rd_mux;
  logic        mem_en_unused, io_en_unused;
  logic [7:0]  int_line_q;

  assign is_rd = req_valid && (req_cmd == CMD_CFG_RD);
  assign is_wr = req_valid && (req_cmd == CMD_CFG_WR);
  assign idx_i = int'(req_index);

  assign wr_cs   = is_wr && (idx_i == IDX_CMDSTAT);
  assign wr_mem  = is_wr && (idx_i == IDX_MEMBAR);
  assign wr_io   = is_wr && (idx_i == IDX_IOBAR);
  assign wr_rom  = is_wr && (idx_i == IDX_ROMBAR);
  assign wr_intr = is_wr && (idx_i == IDX_INTR);

  always_comb begin
    evt_set         = '0;
    evt_set[ST_DPE] = evt_parity_det;
    evt_set[ST_SSE] = evt_serr_sig;
    evt_set[ST_RMA] = evt_master_abort;
    evt_set[ST_RTA] = evt_tabort_rcv;
    evt_set[ST_STA] = evt_tabort_sig;
    evt_set[ST_MDPE] = evt_master_dpe;
  end

  cfg_cmd_status #(.SEL_TIMING(SEL_TIMING), .FB2B_CAP(FB2B_CAP)) u_cs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cs), .wdata(req_wdata), .be(req_be),
    .evt_set(evt_set), .cmd_o(cmd_w), .status_o(status_w)
  );

  cfg_bar #(.SIZE_LOG2(MEM_SIZE_LOG2), .LOW_BITS(MEM_LOW), .HAS_ENABLE(1'b0)) u_mem_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mem), .wdata(req_wdata), .be(req_be),
    .rdata(mem_rd), .enable(mem_en_unused)
  );

  cfg_bar #(.SIZE_LOG2(IO_SIZE_LOG2), .LOW_BITS(4'b0001), .HAS_ENABLE(1'b0)) u_io_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_io), .wdata(req_wdata), .be(req_be),
    .rdata(io_rd), .enable(io_en_unused)
  );

  cfg_bar #(.SIZE_LOG2(ROM_SIZE_LOG2), .LOW_BITS(4'b0000), .HAS_ENABLE(1'b1)) u_rom_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_rom), .wdata(req_wdata), .be(req_be),
    .rdata(rom_rd), .enable(rom_decode_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  int_line_q <= '0;
    else if (wr_intr && req_be[0]) int_line_q <= req_wdata[7:0];
  end

  always_comb begin
    case (idx_i)
      IDX_ID:      rd_mux = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTAT: rd_mux = {status_w, cmd_w};
      IDX_CLASS:   rd_mux = {CLASS_CODE, REVISION};
      IDX_MEMBAR:  rd_mux = mem_rd;
      IDX_IOBAR:   rd_mux = io_rd;
      IDX_ROMBAR:  rd_mux = rom_rd;
      IDX_INTR:    rd_mux = {16'd0, INT_PIN, int_line_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= is_rd || is_wr;
      rsp_rdata <= is_rd ? rd_mux : 32'd0;
    end
  end

  assign io_space_en   = cmd_w[0];
  assign mem_space_en  = cmd_w[1];
  assign bus_master_en = cmd_w[2];
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk
  import cfg_hdr_pkg::*;
#(
  parameter int IDX_W         = 6,
  parameter int MEM_SIZE_LOG2 = 12,
  parameter int IO_SIZE_LOG2  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [3:0]       req_cmd,
  input logic [IDX_W-1:0] req_index,
  input logic [3:0]       req_be,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             evt_master_abort,
  input logic [15:0]      status_w,
  input logic             io_space_en,
  input logic             mem_space_en,
  input logic             bus_master_en
);
  localparam logic [31:0] MEM_ZERO = ((32'd1 << MEM_SIZE_LOG2) - 32'd1) & ~32'h0000_000E;
  localparam logic [31:0] IO_ZERO  = ((32'd1 << IO_SIZE_LOG2) - 32'd1) & ~32'h0000_0001;

  logic cfg_req, rd_req;
  assign cfg_req = req_valid && (req_cmd == CMD_CFG_RD || req_cmd == CMD_CFG_WR);
  assign rd_req  = req_valid && (req_cmd == CMD_CFG_RD);

  a_r1_other_cmd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_req) |=> !rsp_valid);

  a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> rsp_valid);

  a_r3_cmd_lane_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == CMD_CFG_WR && int'(req_index) == IDX_CMDSTAT && !req_be[0])
      |=> $stable({io_space_en, mem_space_en, bus_master_en}));

  a_r4_mem_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && int'(req_index) == IDX_MEMBAR) |=> ((rsp_rdata & MEM_ZERO) == 32'd0));

  a_r5_io_low_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && int'(req_index) == IDX_IOBAR)
      |=> (rsp_rdata[0] && (rsp_rdata & IO_ZERO) == 32'd0));

  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_master_abort |=> status_w[ST_RMA]);

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == CMD_CFG_WR && int'(req_index) == IDX_CMDSTAT &&
     req_be[3] && req_wdata[16 + ST_RMA] && !evt_master_abort) |=> !status_w[ST_RMA]);
endmodule

bind cfg_header_regs cfg_header_regs_chk #(
  .IDX_W(IDX_W), .MEM_SIZE_LOG2(MEM_SIZE_LOG2), .IO_SIZE_LOG2(IO_SIZE_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_index(req_index), .req_be(req_be), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_master_abort(evt_master_abort),
  .status_w(status_w), .io_space_en(io_space_en), .mem_space_en(mem_space_en),
  .bus_master_en(bus_master_en)
);

// File: tb/tb_cfg_header_regs.sv
module tb_cfg_header_regs;
  localparam logic [15:0] VID = 16'h3C5A;
  localparam logic [15:0] DID = 16'h9E21;
  localparam logic [23:0] CC  = 24'h0C0330;
  localparam logic [7:0]  REV = 8'h07;
  localparam logic [7:0]  IPN = 8'h02;
  localparam int          MSL = 12;
  localparam logic [1:0]  MTY = 2'b01;
  localparam bit          MPF = 1'b1;
  localparam int          ISL = 8;
  localparam int          RSL = 14;
  localparam logic [1:0]  SLT = 2'b10;
  localparam bit          FBC = 1'b0;
  localparam logic [3:0]  RD  = 4'b1010;
  localparam logic [3:0]  WR  = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_cmd = '0, req_be = '0;
  logic [5:0] req_index = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [5:0] ev = '0; // {dpe, sse, rma, rta, sta, mdpe}
  logic io_en, mem_en, bm_en, rom_en;

  int vectors = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [15:0] cmd_m, sticky_m;
  logic [31:0] mem_m, io_m, rom_m;
  logic [7:0]  intl_m;

  always #10 clk = ~clk;

  cfg_header_regs #(
    .IDX_W(6), .VENDOR_ID(VID), .DEVICE_ID(DID), .CLASS_CODE(CC), .REVISION(REV),
    .INT_PIN(IPN), .MEM_SIZE_LOG2(MSL), .MEM_TYPE(MTY), .MEM_PREFETCH(MPF),
    .IO_SIZE_LOG2(ISL), .ROM_SIZE_LOG2(RSL), .SEL_TIMING(SLT), .FB2B_CAP(FBC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_index(req_index), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .evt_parity_det(ev[5]), .evt_serr_sig(ev[4]), .evt_master_abort(ev[3]),
    .evt_tabort_rcv(ev[2]), .evt_tabort_sig(ev[1]), .evt_master_dpe(ev[0]),
    .io_space_en(io_en), .mem_space_en(mem_en), .bus_master_en(bm_en),
    .rom_decode_en(rom_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic logic [15:0] ev_bits(input logic [5:0] e);
    return {e[5], e[4], e[3], e[2], e[1], 2'b00, e[0], 8'h00};
  endfunction

  function automatic logic [31:0] mread(input int i);
    case (i)
      0:  return {DID, VID};
      1:  return {sticky_m | {5'd0, SLT, 1'b0, FBC, 7'd0}, cmd_m};
      2:  return {CC, REV};
      4:  return mem_m | {28'd0, MPF, MTY, 1'b0};
      5:  return io_m | 32'd1;
      12: return rom_m;
      15: return {16'd0, IPN, intl_m};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(input int i);
    case (i)
      0, 2: return "R10";
      1:    return "R8/R9";
      4:    return "R4";
      5:    return "R5";
      12:   return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic mwrite(input int i, input logic [3:0] be, input logic [31:0] wd);
    logic [15:0] clr;
    case (i)
      1: begin
        cmd_m = merge({16'd0, cmd_m}, wd, be)[15:0] & 16'h03FF;
        clr = wd[31:16] & {{8{be[3]}}, {8{be[2]}}} & 16'hF900;
        sticky_m = sticky_m & ~clr;
      end
      4:  mem_m = merge(mem_m, wd, be) & ~((32'd1 << MSL) - 1);
      5:  io_m  = merge(io_m, wd, be) & ~((32'd1 << ISL) - 1);
      12: rom_m = merge(rom_m, wd, be) & (~((32'd1 << RSL) - 1) | 32'd1);
      15: if (be[0]) intl_m = wd[7:0];
      default: ;
    endcase
  endtask

  task automatic access(input logic [3:0] c, input int i, input logic [3:0] be,
                        input logic [31:0] wd, input logic [5:0] e);
    bit is_cfg;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_index = i[5:0]; req_be = be; req_wdata = wd; ev = e;
    is_cfg = (c == RD) || (c == WR);
    exp = (c == RD) ? mread(i) : 32'd0;
    @(negedge clk);
    req_valid = 1'b0; ev = '0;
    if (is_cfg) begin
      check(rsp_valid === 1'b1, "R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(rsp_rdata === exp, (c == RD) ? rtag(i) : "R2 write data", rsp_rdata, exp);
    end else begin
      check(rsp_valid === 1'b0, "R1 no response", {31'd0, rsp_valid}, 32'd0);
    end
    if (c == WR) mwrite(i, be, wd);
    sticky_m = sticky_m | ev_bits(e);
    check({io_en, mem_en, bm_en, rom_en} === {cmd_m[0], cmd_m[1], cmd_m[2], rom_m[0]},
          "R8/R6 enables", {28'd0, io_en, mem_en, bm_en, rom_en},
          {28'd0, cmd_m[0], cmd_m[1], cmd_m[2], rom_m[0]});
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] cmds [8] = '{RD, WR, RD, WR, RD, WR, 4'b0110, 4'b0011};
    void'($urandom(32'd2024));
    cmd_m = '0; sticky_m = '0; mem_m = '0; io_m = '0; rom_m = '0; intl_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check({io_en, mem_en, bm_en, rom_en, rsp_valid} === 5'd0, "R12 reset outputs",
          {27'd0, io_en, mem_en, bm_en, rom_en, rsp_valid}, 32'd0);
    access(RD, 1, 4'h0, 0, 0);   // R12 / R9 command and status
    access(RD, 4, 4'h0, 0, 0);   // R12 mem base zero
    access(RD, 15, 4'h0, 0, 0);
    // R10 read-only fields ignore writes
    access(WR, 0, 4'hF, 32'hFFFF_FFFF, 0);
    access(RD, 0, 4'h0, 0, 0);
    access(WR, 2, 4'hF, 32'h1234_5678, 0);
    access(RD, 2, 4'h0, 0, 0);
    // R4 R5 R6 sizing
    access(WR, 4, 4'hF, 32'hFFFF_FFFF, 0);
    access(RD, 4, 4'h0, 0, 0);
    access(WR, 5, 4'hF, 32'hFFFF_FFFF, 0);
    access(RD, 5, 4'h0, 0, 0);
    access(WR, 12, 4'hF, 32'hFFFF_FFFF, 0);
    access(RD, 12, 4'h0, 0, 0);
    access(WR, 12, 4'h1, 32'h0, 0);   // disable ROM decode
    // R3 R8 partial lanes
    access(WR, 1, 4'h1, 32'hFFFF_FFFF, 0);
    access(RD, 1, 4'h0, 0, 0);
    access(WR, 1, 4'h2, 32'h0000_0000, 0);
    access(RD, 1, 4'h0, 0, 0);
    // R1 ignored command (memory write code) to command dword
    access(4'b0111, 1, 4'hF, 32'h0000_0000, 0);
    access(RD, 1, 4'h0, 0, 0);
    // R7 sticky set, clear, set-over-clear
    access(RD, 3, 4'h0, 0, 6'b001000);
    access(RD, 1, 4'h0, 0, 0);
    access(WR, 1, 4'h7, 32'hFFFF_FFFF, 0); // be[3] low: no clear
    access(RD, 1, 4'h0, 0, 0);
    access(WR, 1, 4'h8, 32'h2000_0000, 0); // clear RMA
    access(RD, 1, 4'h0, 0, 0);
    access(RD, 1, 4'h0, 0, 6'b111111);
    access(WR, 1, 4'h8, 32'hFF00_0000, 6'b001000); // event wins on RMA
    access(RD, 1, 4'h0, 0, 0);
    // R11 interrupt line and zero areas
    access(WR, 15, 4'h3, 32'h0000_FF5A, 0);
    access(RD, 15, 4'h0, 0, 0);
    access(RD, 40, 4'h0, 0, 0);
    access(RD, 63, 4'h0, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int idx;
      idx = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 15));
      access(cmds[$urandom_range(0, 7)], idx, 4'($urandom_range(0, 15)), $urandom(),
             ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'd0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule